// File: doc/BRIEF.md
# Rewindable FIFO with Mark Pointer

A single-clock first-in first-out buffer of 9-bit words whose depth is a power-of-two parameter. Besides the usual read and write pointers it keeps a third, the mark pointer. A mark request stores the current read position, which is usually the first word of a packet. A later rewind request moves the read pointer back to that stored position, so the same words can be read again. Rewinds may be repeated as often as needed, and the mark may be moved forward at any time.

Read data comes out of a register together with a valid strobe, which stands in for an output enable. The strobe is low whenever no read took place in the cycle before. The block reports its occupancy as the write pointer minus the read pointer, and an external flag generator can decode thresholds from it. It also drives full and empty. While a mark is held, full is judged against the mark position, so that marked words can never be overwritten. A write refused for that reason alone raises a one-cycle blocked pulse.

Top module: `rewind_fifo`

## Requirements
- R1: Words are returned on `rd_data` in the order in which they were accepted.
- R2: While `rst_n` is low at a rising clock edge, the read, write and mark pointers clear to zero and no mark is held. In the cycle after that edge `level` is 0, `empty` is 1, and `full`, `rd_valid` and `wr_blocked` are 0.
- R3: A write request while `full` is 1 is dropped. It changes neither `level` nor any stored word.
- R4: A read request while `empty` is 1 is dropped, and `rd_valid` is 0 in the next cycle.
- R5: `rd_valid` is 1 in exactly the cycle after an accepted read, with the word on `rd_data`. Otherwise it is 0.
- R6: `mark_en` stores the read position as it stands before that cycle's read. `rewind_en` loads the read pointer from the mark. In the next cycle `level` equals the writes since the marked word, and reads continue from the marked word in order.
- R7: Rewinding repeatedly to the same mark replays the same word sequence each time.
- R8: While a mark is held, `full` is 1 when the writes since the marked word reach DEPTH, even if `level` is lower. A write request refused with `level` below DEPTH drives `wr_blocked` high in that same cycle.
- R9: When `mark_en` and `rewind_en` are both high, the rewind uses the previously stored mark and the new mark is discarded.
- R10: A read request in the same cycle as `rewind_en` is ignored, and `rd_valid` is 0 in the next cycle.
- R11: `level` always equals accepted writes minus current read position, and stays in 0..DEPTH. With no mark held, `full` is 1 exactly when `level` equals DEPTH.
- R12: A read and a write in the same cycle on a FIFO that is neither empty nor full are both accepted, and `level` is unchanged.
- R13: `rewind_en` before any mark has been stored after reset leaves the read pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state changes on its rising edge |
| rst_n | input | 1 | Synchronous master reset, active low |
| wr_en | input | 1 | Write request |
| wr_data | input | WIDTH | Word to store |
| rd_en | input | 1 | Read request |
| rd_data | output | WIDTH | Registered read word, meaningful while rd_valid is 1 |
| rd_valid | output | 1 | Output enable, high the cycle after an accepted read |
| mark_en | input | 1 | Store current read position as the mark |
| rewind_en | input | 1 | Reload the read pointer from the mark |
| level | output | $clog2(DEPTH)+1 | Occupancy: write pointer minus read pointer |
| full | output | 1 | Write would be refused (capacity or mark guard) |
| empty | output | 1 | No unread word |
| wr_blocked | output | 1 | Write request refused only because of the mark guard |

## Verification
`full`, `empty`, `level` and `wr_blocked` are decoded combinationally from pointer registers and the present requests. They settle after the edge that updates the pointers, so the bench reads them just before the next rising edge, after it has applied that cycle's requests. `rd_data` and `rd_valid` come out of registers one edge after the read request, and the bench reads them shortly after that edge. A behavioural model built on a growing word history and integer indices predicts both groups. Its result is compared with the design on every cycle, including the cycles right after a rewind, when the occupancy jumps back by the number of words replayed.

// File: rtl/rfifo_pkg.sv
package rfifo_pkg;

  localparam int SPAN_W = 32;
  typedef logic [SPAN_W-1:0] span_t;

  typedef enum logic [1:0] {
    RD_HOLD   = 2'd0,
    RD_STEP   = 2'd1,
    RD_REWIND = 2'd2
  } rd_act_e;

  // distance from 'behind' to 'ahead' on a ring of 2**bits positions
  function automatic span_t ring_span(span_t ahead, span_t behind, int unsigned bits);
    span_t mask;
    mask = (span_t'(1) << bits) - span_t'(1);
    return (ahead - behind) & mask;
  endfunction

  // capacity guard: a span that has reached the depth blocks writes
  function automatic logic span_at_cap(span_t span, int unsigned depth);
    return span >= span_t'(depth);
  endfunction

endpackage

// File: rtl/rfifo_store.sv
module rfifo_store #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_fire,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic             rd_fire,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data,
  output logic             rd_valid
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_fire) begin
      mem[wr_addr] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_fire;
      if (rd_fire) begin
        rd_data <= mem[rd_addr];
      end
    end
  end

endmodule

// File: rtl/rfifo_status.sv
module rfifo_status #(
  parameter int DEPTH = 16,
  parameter int PW    = 5
) (
  input  logic          wr_req,
  input  logic [PW-1:0] wr_ptr,
  input  logic [PW-1:0] rd_ptr,
  input  logic [PW-1:0] mark_ptr,
  input  logic          mark_held,
  output logic [PW-1:0] level,
  output logic [PW-1:0] mark_span,
  output logic          full,
  output logic          empty,
  output logic          wr_blocked
);
  import rfifo_pkg::*;

  logic cap_full;
  logic guard_full;

  assign level     = PW'(ring_span(span_t'(wr_ptr), span_t'(rd_ptr), PW));
  assign mark_span = PW'(ring_span(span_t'(wr_ptr), span_t'(mark_ptr), PW));

  assign cap_full   = span_at_cap(span_t'(level), DEPTH);
  assign guard_full = mark_held && span_at_cap(span_t'(mark_span), DEPTH);

  assign full       = cap_full || guard_full;
  assign empty      = (wr_ptr == rd_ptr);
  assign wr_blocked = wr_req && guard_full && !cap_full;

endmodule

// File: rtl/rfifo_ptr_ctl.sv
module rfifo_ptr_ctl #(
  parameter int PW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic          rd_req,
  input  logic          mark_req,
  input  logic          rewind_req,
  input  logic          full,
  input  logic          empty,
  output logic [PW-1:0] wr_ptr,
  output logic [PW-1:0] rd_ptr,
  output logic [PW-1:0] mark_ptr,
  output logic          mark_held,
  output logic          wr_fire,
  output logic          rd_fire,
  output logic          rewind_fire
);
  import rfifo_pkg::*;

  rd_act_e rd_act;
  logic    mark_fire;

  assign wr_fire     = wr_req && !full;
  assign rd_fire     = rd_req && !empty && !rewind_req;
  assign rewind_fire = rewind_req && mark_held;
  assign mark_fire   = mark_req && !rewind_req;

  always_comb begin
    if (rewind_fire)  rd_act = RD_REWIND;
    else if (rd_fire) rd_act = RD_STEP;
    else              rd_act = RD_HOLD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      mark_ptr  <= '0;
      mark_held <= 1'b0;
    end else begin
      if (wr_fire) begin
        wr_ptr <= wr_ptr + PW'(1);
      end
      case (rd_act)
        RD_STEP:   rd_ptr <= rd_ptr + PW'(1);
        RD_REWIND: rd_ptr <= mark_ptr;
        default:   rd_ptr <= rd_ptr;
      endcase
      if (mark_fire) begin
        mark_ptr  <= rd_ptr;
        mark_held <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/rewind_fifo.sv
module rewind_fifo #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [WIDTH-1:0]           wr_data,
  input  logic                       rd_en,
  output logic [WIDTH-1:0]           rd_data,
  output logic                       rd_valid,
  input  logic                       mark_en,
  input  logic                       rewind_en,
  output logic [$clog2(DEPTH):0]     level,
  output logic                       full,
  output logic                       empty,
  output logic                       wr_blocked
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [PW-1:0] wr_ptr;
  logic [PW-1:0] rd_ptr;
  logic [PW-1:0] mark_ptr;
  logic [PW-1:0] mark_span;
  logic          mark_held;
  logic          wr_fire;
  logic          rd_fire;
  logic          rewind_fire;

  rfifo_status #(
    .DEPTH (DEPTH),
    .PW    (PW)
  ) u_status (
    .wr_req     (wr_en),
    .wr_ptr     (wr_ptr),
    .rd_ptr     (rd_ptr),
    .mark_ptr   (mark_ptr),
    .mark_held  (mark_held),
    .level      (level),
    .mark_span  (mark_span),
    .full       (full),
    .empty      (empty),
    .wr_blocked (wr_blocked)
  );

  rfifo_ptr_ctl #(
    .PW (PW)
  ) u_ptr (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_req      (wr_en),
    .rd_req      (rd_en),
    .mark_req    (mark_en),
    .rewind_req  (rewind_en),
    .full        (full),
    .empty       (empty),
    .wr_ptr      (wr_ptr),
    .rd_ptr      (rd_ptr),
    .mark_ptr    (mark_ptr),
    .mark_held   (mark_held),
    .wr_fire     (wr_fire),
    .rd_fire     (rd_fire),
    .rewind_fire (rewind_fire)
  );

  rfifo_store #(
    .WIDTH (WIDTH),
    .DEPTH (DEPTH),
    .AW    (AW)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_fire  (wr_fire),
    .wr_addr  (wr_ptr[AW-1:0]),
    .wr_data  (wr_data),
    .rd_fire  (rd_fire),
    .rd_addr  (rd_ptr[AW-1:0]),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

endmodule

// File: rtl/rewind_fifo_chk.sv
module rewind_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int PW    = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic          rewind_en,
  input logic          rd_valid,
  input logic [PW-1:0] level,
  input logic [PW-1:0] mark_span,
  input logic          full,
  input logic          empty,
  input logic          wr_blocked,
  input logic          mark_held,
  input logic          wr_fire,
  input logic          rd_fire,
  input logic          rewind_fire
);

  // R2
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (level == '0 && empty && !full && !rd_valid));

  // R3
  full_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (full && wr_en && !rd_en && !rewind_en) |=> level == $past(level));

  // R4
  empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && rd_en) |=> !rd_valid);

  // R5
  valid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fire |=> rd_valid);

  // R5
  valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_fire |=> !rd_valid);

  // R6
  rewind_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rewind_fire && !wr_fire) |=> level == $past(mark_span));

  // R8
  blocked_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_blocked |-> (full && wr_en && mark_held));

  // R10
  rewind_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rewind_en |=> !rd_valid);

  // R11
  level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    level <= PW'(DEPTH));

  // R11
  plain_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mark_held && full) |-> level == PW'(DEPTH));

endmodule

bind rewind_fifo rewind_fifo_chk #(
  .DEPTH (DEPTH),
  .PW    (PW)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .wr_en       (wr_en),
  .rd_en       (rd_en),
  .rewind_en   (rewind_en),
  .rd_valid    (rd_valid),
  .level       (level),
  .mark_span   (mark_span),
  .full        (full),
  .empty       (empty),
  .wr_blocked  (wr_blocked),
  .mark_held   (mark_held),
  .wr_fire     (wr_fire),
  .rd_fire     (rd_fire),
  .rewind_fire (rewind_fire)
);

// File: tb/rewind_fifo_bench.sv
module rewind_fifo_bench;

  localparam int WIDTH = 9;
  localparam int DEPTH = 16;
  localparam int PW    = $clog2(DEPTH) + 1;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [WIDTH-1:0] wr_data = '0;
  logic             rd_en = 1'b0;
  logic             mark_en = 1'b0;
  logic             rewind_en = 1'b0;
  logic [WIDTH-1:0] rd_data;
  logic             rd_valid;
  logic [PW-1:0]    level;
  logic             full;
  logic             empty;
  logic             wr_blocked;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // behavioural reference: full write history plus integer indices
  logic [WIDTH-1:0] hist[$];
  int  wr_cnt, rd_idx, mark_idx;
  bit  mark_on;
  logic [WIDTH-1:0] exp_data;
  bit  exp_valid;
  bit  last_blocked;
  int  seq = 1;

  always #5 clk = ~clk;

  rewind_fifo u_rewind_fifo (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .rd_en      (rd_en),
    .rd_data    (rd_data),
    .rd_valid   (rd_valid),
    .mark_en    (mark_en),
    .rewind_en  (rewind_en),
    .level      (level),
    .full       (full),
    .empty      (empty),
    .wr_blocked (wr_blocked)
  );

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit model_full();
    if (mark_on) return (wr_cnt - mark_idx) >= DEPTH;
    return (wr_cnt - rd_idx) >= DEPTH;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; wr_en = 0; rd_en = 0; mark_en = 0; rewind_en = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    hist.delete();
    wr_cnt = 0; rd_idx = 0; mark_idx = 0; mark_on = 0; exp_valid = 0;
    #1;
    chk(level == 0, "R2", "level", int'(level), 0);
    chk(empty == 1'b1, "R2", "empty", int'(empty), 1);
    chk(full == 1'b0, "R2", "full", int'(full), 0);
    chk(rd_valid == 1'b0, "R2", "rd_valid", int'(rd_valid), 0);
    chk(wr_blocked == 1'b0, "R2", "wr_blocked", int'(wr_blocked), 0);
  endtask

  // one clock: drive at falling edge, check decoded outputs before the rising
  // edge, update the model, check registered outputs just after the edge
  task automatic step(input bit w, input bit r, input bit m, input bit rt, input string tag);
    int  lvl;
    bit  e_full, e_empty, e_blk, wacc, racc;
    int  old_rd;
    @(negedge clk);
    wr_en = w; rd_en = r; mark_en = m; rewind_en = rt;
    wr_data = WIDTH'(seq * 37 + 5);
    #1;
    lvl     = wr_cnt - rd_idx;
    e_full  = model_full();
    e_empty = (lvl == 0);
    e_blk   = w && e_full && (lvl < DEPTH);
    chk(int'(level) == lvl, tag, "level", int'(level), lvl);
    chk(full == e_full, tag, "full", int'(full), int'(e_full));
    chk(empty == e_empty, tag, "empty", int'(empty), int'(e_empty));
    chk(wr_blocked == e_blk, tag, "wr_blocked", int'(wr_blocked), int'(e_blk));
    last_blocked = wr_blocked;
    wacc = w && !e_full;
    racc = r && !e_empty && !rt;
    old_rd = rd_idx;
    @(posedge clk);
    if (wacc) begin
      hist.push_back(wr_data);
      wr_cnt++;
      seq++;
    end
    if (rt) begin
      if (mark_on) rd_idx = mark_idx;
    end else if (racc) begin
      exp_data = hist[rd_idx];
      rd_idx++;
    end
    if (m && !rt) begin
      mark_idx = old_rd;
      mark_on  = 1'b1;
    end
    exp_valid = racc;
    #1;
    chk(rd_valid == exp_valid, tag, "rd_valid", int'(rd_valid), int'(exp_valid));
    if (exp_valid) chk(rd_data == exp_data, tag, "rd_data", int'(rd_data), int'(exp_data));
  endtask

  initial begin
    int start_lvl;
    int v;
    do_reset();

    // order and output-enable timing
    for (int i = 0; i < 5; i++) step(1, 0, 0, 0, "R1");
    for (int i = 0; i < 5; i++) step(0, 1, 0, 0, "R5");
    step(0, 0, 0, 0, "R5");

    // read on empty
    step(0, 1, 0, 0, "R4");
    chk(rd_valid == 1'b0, "R4", "rd_valid after empty read", int'(rd_valid), 0);

    // fill past capacity, no mark held
    for (int i = 0; i < DEPTH + 2; i++) step(1, 0, 0, 0, "R3");
    chk(int'(level) == DEPTH, "R3", "level at capacity", int'(level), DEPTH);
    for (int i = 0; i < DEPTH; i++) step(0, 1, 0, 0, "R1");

    // concurrent read and write
    for (int i = 0; i < 3; i++) step(1, 0, 0, 0, "R12");
    for (int i = 0; i < 6; i++) step(1, 1, 0, 0, "R12");
    chk(int'(level) == 3, "R12", "level after concurrent ops", int'(level), 3);
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0, "R12");

    // rewind before any mark
    step(1, 0, 0, 0, "R13");
    step(1, 0, 0, 0, "R13");
    step(0, 0, 0, 1, "R13");
    chk(int'(level) == 2, "R13", "level after unmarked rewind", int'(level), 2);
    step(0, 1, 0, 0, "R13");
    step(0, 1, 0, 0, "R13");

    // mark, read, rewind, replay twice
    for (int i = 0; i < 6; i++) step(1, 0, 0, 0, "R6");
    step(0, 0, 1, 0, "R6");
    v = int'(hist[mark_idx]);
    for (int i = 0; i < 3; i++) step(0, 1, 0, 0, "R6");
    step(0, 0, 0, 1, "R6");
    chk(int'(level) == 6, "R6", "level after rewind", int'(level), 6);
    step(0, 1, 0, 0, "R6");
    chk(int'(rd_data) == v, "R6", "first word after rewind", int'(rd_data), v);
    for (int i = 0; i < 2; i++) step(0, 1, 0, 0, "R7");
    step(0, 0, 0, 1, "R7");
    step(0, 1, 0, 0, "R7");
    chk(int'(rd_data) == v, "R7", "first word after second rewind", int'(rd_data), v);

    // read together with rewind
    step(0, 1, 0, 1, "R10");
    chk(rd_valid == 1'b0, "R10", "rd_valid after read+rewind", int'(rd_valid), 0);
    chk(int'(level) == 6, "R10", "level after read+rewind", int'(level), 6);

    // mark and rewind in one cycle
    step(0, 1, 0, 0, "R9");
    step(0, 1, 0, 0, "R9");
    step(0, 0, 1, 1, "R9");
    for (int i = 0; i < 4; i++) step(0, 1, 0, 0, "R9");
    step(0, 0, 0, 1, "R9");
    chk(int'(level) == 6, "R9", "rewind target kept old mark", int'(level), 6);

    // mark guard reaches capacity while level is lower
    for (int i = 0; i < 14; i++) step(1, 1, 0, 0, "R8");
    start_lvl = int'(level);
    step(1, 0, 0, 0, "R8");
    chk(full == 1'b1 && start_lvl < DEPTH, "R8", "guard full below capacity", int'(full), 1);
    chk(last_blocked == 1'b1, "R8", "wr_blocked on guarded write", int'(last_blocked), 1);
    step(0, 0, 1, 0, "R8");
    step(1, 0, 0, 0, "R8");
    chk(last_blocked == 1'b0, "R8", "wr_blocked after mark moved", int'(last_blocked), 0);

    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      step(($urandom % 2) == 0, ($urandom % 2) == 0,
           ($urandom % 16) == 0, ($urandom % 20) == 0, "R11");
    end

    do_reset();
    step(0, 0, 0, 1, "R2");
    chk(empty == 1'b1, "R2", "empty after reset and rewind", int'(empty), 1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule